// File: doc/BRIEF.md
# Serial Audio Input Receiver

This block takes a two-channel audio stream sent one bit at a time, with the left and right words taking turns, and turns it into parallel samples. Three lines carry the stream: a bit clock, a data line and a word clock whose level tells which channel is being sent. All three are treated as asynchronous. They pass through a synchroniser into the system clock, and every edge is found in the system clock domain. No logic is clocked by the bit clock.

Each word is sent most-significant bit first, in two's complement, and is right-justified within its word-clock half. The last bit before a word-clock transition is therefore the LSB, and any bits before the word are ignored. A falling edge of the bit clock shifts one data bit into a 32-bit register. A word-clock transition ends the current half-word. The shift register is then normalised from the selected word length (16, 20, 24 or 32 bits) to a 24-bit sample and stored in the register of the channel that just ended. A one-cycle strobe marks each update.

A three-state controller tracks the channel being received. The states are `ST_ALIGN`, `ST_LEFT` and `ST_RIGHT`. After reset it waits in `ST_ALIGN` and leaves on the first word-clock transition (transition `T_ALIGN_DONE`), because the half-word in flight at that point is incomplete. On each later transition it stores the channel that ended: `T_LEFT_END` leaves `ST_LEFT` and `T_RIGHT_END` leaves `ST_RIGHT`. It then enters the state that the new word-clock level and the polarity select decode to.

Top module: `serial_audio_rx`

## Requirements
- R1: During reset and right after it, both sample outputs are zero and all three strobes are low.
- R2: A data bit is shifted in only on a falling edge of the bit clock, MSB first. The sample is taken from the last bits received before the word-clock transition, so bits that arrive ahead of a shorter word have no effect on it.
- R3: With `left_is_high_i` = 1, a word sent while the word clock is high is left and a word sent while it is low is right. With `left_is_high_i` = 0 the mapping is swapped. Each stored word goes only to its own channel's output.
- R4: Word-length code 2'b10 selects 24 bits, and the 24 received bits appear unchanged on the output.
- R5: Code 2'b00 selects 32 bits. The output is the upper 24 bits, and the lower 8 bits are dropped without rounding.
- R6: Code 2'b11 selects 20 bits. The output is the 20 received bits followed by four zero LSBs.
- R7: Code 2'b01 selects 16 bits. The output is the 16 received bits followed by eight zero LSBs.
- R8: Each channel's strobe is high for exactly one cycle per stored word, and the two channel strobes are never high together. A sample output keeps its value until that channel's next strobe.
- R9: The frame strobe is high in exactly the cycles in which the right-channel strobe is high.
- R10: The half-word that ends at the first word-clock transition after reset produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bclk_i | input | 1 | Serial bit clock (asynchronous) |
| sdata_i | input | 1 | Serial data (asynchronous) |
| wclk_i | input | 1 | Word clock / channel select (asynchronous) |
| left_is_high_i | input | 1 | 1: word clock high means left; 0: word clock high means right |
| word_len_i | input | 2 | Word length: 00 = 32, 01 = 16, 10 = 24, 11 = 20 bits |
| left_sample_o | output | 24 | Latest left-channel sample |
| left_valid_o | output | 1 | One-cycle strobe when the left sample updates |
| right_sample_o | output | 24 | Latest right-channel sample |
| right_valid_o | output | 1 | One-cycle strobe when the right sample updates |
| frame_valid_o | output | 1 | One-cycle strobe marking the end of a left/right frame |

## Verification
The bench builds the block with its defaults: a 32-bit shift register, 24-bit samples and a two-stage synchroniser. With these defaults, all four word-length codes are reachable, including the two that pad and the one that truncates. The 32-bit shift register also leaves room to put filler bits ahead of every shorter word, and the bench uses that room to show the filler is ignored. The bit clock runs at one-eighth of the system clock, and each word-clock transition is placed several cycles away from any bit-clock edge, so shifts and captures never fall in the same cycle. The bench runs both polarity settings and checks the first half-word discarded after reset.

// File: rtl/sarx_pkg.sv
`timescale 1ns/1ps
package sarx_pkg;

    // Which half-word the receiver is currently collecting.
    typedef enum logic [1:0] {
        ST_ALIGN = 2'b00,
        ST_LEFT  = 2'b01,
        ST_RIGHT = 2'b10
    } rx_state_t;

    // Encodings of the word-length select.
    typedef enum logic [1:0] {
        WL_32 = 2'b00,
        WL_16 = 2'b01,
        WL_24 = 2'b10,
        WL_20 = 2'b11
    } wlen_t;

    localparam int unsigned NUM_WLEN = 4;

    // Number of significant bits carried by each word-length code.
    function automatic int unsigned wlen_bits(input int unsigned code);
        case (code)
            0:       return 32;
            1:       return 16;
            2:       return 24;
            default: return 20;
        endcase
    endfunction

endpackage

// File: rtl/sarx_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser, one chain per input bit.
module sarx_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '0;
                end else begin
                    chain <= {chain[STAGES-2:0], async_i[b]};
                end
            end

            assign sync_o[b] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/sarx_shift.sv
`timescale 1ns/1ps
// Serial-to-parallel register. The newest bit enters at position 0, so the
// word's LSB sits at bit 0 when its half ends.
module sarx_shift #(
    parameter int unsigned SHIFT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               bit_i,
    output logic [SHIFT_W-1:0] word_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_o <= '0;
        end else if (shift_en) begin
            word_o <= {word_o[SHIFT_W-2:0], bit_i};
        end
    end

    // R2: a shift moves the old contents up by one and takes in the sampled bit.
    p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (word_o[0] == $past(bit_i)) &&
                     (word_o[SHIFT_W-1:1] == $past(word_o[SHIFT_W-2:0])));

    // R2: with no falling bit-clock edge the register holds.
    p_shift_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(word_o));

endmodule

// File: rtl/sarx_norm.sv
`timescale 1ns/1ps
// Maps a right-justified word of the selected length onto OUT_W bits:
// longer words are truncated at the bottom, shorter ones are zero-filled.
module sarx_norm
    import sarx_pkg::*;
#(
    parameter int unsigned SHIFT_W = 32,
    parameter int unsigned OUT_W   = 24
) (
    input  logic [SHIFT_W-1:0] word_i,
    input  logic [1:0]         wlen_i,
    output logic [OUT_W-1:0]   sample_o
);

    logic [OUT_W-1:0] cand [NUM_WLEN];

    generate
        for (genvar k = 0; k < NUM_WLEN; k++) begin : g_len
            localparam int unsigned LBITS = wlen_bits(k);
            if (LBITS >= OUT_W) begin : g_trunc
                assign cand[k] = word_i[LBITS-1 -: OUT_W];
            end else begin : g_pad
                assign cand[k] = {word_i[LBITS-1:0], {(OUT_W-LBITS){1'b0}}};
            end
        end
    endgenerate

    always_comb begin
        sample_o = cand[wlen_i];
    end

endmodule

// File: rtl/sarx_fsm.sv
`timescale 1ns/1ps
// Channel-tracking controller and output registers.
module sarx_fsm
    import sarx_pkg::*;
#(
    parameter int unsigned OUT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wc_edge_i,
    input  logic             wc_level_i,
    input  logic             left_is_high_i,
    input  logic [OUT_W-1:0] sample_i,
    output logic [OUT_W-1:0] left_sample_o,
    output logic             left_valid_o,
    output logic [OUT_W-1:0] right_sample_o,
    output logic             right_valid_o,
    output logic             frame_valid_o
);

    rx_state_t state_q, state_d;
    logic      new_is_left;

    assign new_is_left = (wc_level_i == left_is_high_i);

    // Next state. T_ALIGN_DONE, T_LEFT_END and T_RIGHT_END all go to the
    // channel that the new word-clock level decodes to.
    always_comb begin
        state_d = state_q;
        if (wc_edge_i) begin
            unique case (state_q)
                ST_ALIGN: state_d = new_is_left ? ST_LEFT : ST_RIGHT;
                ST_LEFT:  state_d = new_is_left ? ST_LEFT : ST_RIGHT;
                ST_RIGHT: state_d = new_is_left ? ST_LEFT : ST_RIGHT;
                default:  state_d = ST_ALIGN;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ALIGN;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs: store the channel whose half just ended.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_sample_o  <= '0;
            right_sample_o <= '0;
            left_valid_o   <= 1'b0;
            right_valid_o  <= 1'b0;
            frame_valid_o  <= 1'b0;
        end else begin
            left_valid_o  <= 1'b0;
            right_valid_o <= 1'b0;
            frame_valid_o <= 1'b0;
            if (wc_edge_i) begin
                unique case (state_q)
                    ST_LEFT: begin
                        left_sample_o <= sample_i;
                        left_valid_o  <= 1'b1;
                    end
                    ST_RIGHT: begin
                        right_sample_o <= sample_i;
                        right_valid_o  <= 1'b1;
                        frame_valid_o  <= 1'b1;
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({left_valid_o, right_valid_o}));

    p_left_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        left_valid_o |=> !left_valid_o);

    p_right_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        right_valid_o |=> !right_valid_o);

    p_left_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !left_valid_o |-> $stable(left_sample_o));

    p_right_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !right_valid_o |-> $stable(right_sample_o));

    p_frame_right_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid_o == right_valid_o);

    p_align_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ALIGN) |=> !left_valid_o && !right_valid_o);

endmodule

// File: rtl/serial_audio_rx.sv
`timescale 1ns/1ps
module serial_audio_rx
    import sarx_pkg::*;
#(
    parameter int unsigned SHIFT_W     = 32,
    parameter int unsigned OUT_W       = 24,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_i,
    input  logic             sdata_i,
    input  logic             wclk_i,
    input  logic             left_is_high_i,
    input  logic [1:0]       word_len_i,
    output logic [OUT_W-1:0] left_sample_o,
    output logic             left_valid_o,
    output logic [OUT_W-1:0] right_sample_o,
    output logic             right_valid_o,
    output logic             frame_valid_o
);

    localparam int unsigned SYNC_W = 3;
    localparam int unsigned IDX_BCLK = 0;
    localparam int unsigned IDX_DATA = 1;
    localparam int unsigned IDX_WCLK = 2;

    logic [SYNC_W-1:0]  raw_in, synced;
    logic               bclk_d, wclk_d;
    logic               bclk_fall, wc_edge;
    logic [SHIFT_W-1:0] shreg;
    logic [OUT_W-1:0]   norm_sample;

    assign raw_in = {wclk_i, sdata_i, bclk_i};

    sarx_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (synced)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_d <= 1'b0;
            wclk_d <= 1'b0;
        end else begin
            bclk_d <= synced[IDX_BCLK];
            wclk_d <= synced[IDX_WCLK];
        end
    end

    assign bclk_fall = bclk_d & ~synced[IDX_BCLK];
    assign wc_edge   = wclk_d ^ synced[IDX_WCLK];

    sarx_shift #(.SHIFT_W(SHIFT_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (bclk_fall),
        .bit_i    (synced[IDX_DATA]),
        .word_o   (shreg)
    );

    sarx_norm #(.SHIFT_W(SHIFT_W), .OUT_W(OUT_W)) u_norm (
        .word_i   (shreg),
        .wlen_i   (word_len_i),
        .sample_o (norm_sample)
    );

    sarx_fsm #(.OUT_W(OUT_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .wc_edge_i      (wc_edge),
        .wc_level_i     (synced[IDX_WCLK]),
        .left_is_high_i (left_is_high_i),
        .sample_i       (norm_sample),
        .left_sample_o  (left_sample_o),
        .left_valid_o   (left_valid_o),
        .right_sample_o (right_sample_o),
        .right_valid_o  (right_valid_o),
        .frame_valid_o  (frame_valid_o)
    );

    // R3: a sample is stored only in the cycle after a word-clock transition.
    p_store_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (left_valid_o || right_valid_o) |-> $past(wc_edge));

    // R7: sixteen-bit words leave the low byte of the output clear.
    p_pad16_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (left_valid_o && $past(word_len_i) == WL_16) |-> (left_sample_o[7:0] == '0));

    // R6: twenty-bit words leave the low nibble of the output clear.
    p_pad20_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (right_valid_o && $past(word_len_i) == WL_20) |-> (right_sample_o[3:0] == '0));

endmodule

// File: tb/tb_serial_audio_rx.sv
`timescale 1ns/1ps
module tb_serial_audio_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b1;
    logic        sdata = 1'b0;
    logic        wclk = 1'b0;
    logic        pol = 1'b1;
    logic [1:0]  wlen = 2'b10;
    logic [23:0] left_sample, right_sample;
    logic        left_valid, right_valid, frame_valid;

    always #4 clk = ~clk;

    serial_audio_rx dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .bclk_i         (bclk),
        .sdata_i        (sdata),
        .wclk_i         (wclk),
        .left_is_high_i (pol),
        .word_len_i     (wlen),
        .left_sample_o  (left_sample),
        .left_valid_o   (left_valid),
        .right_sample_o (right_sample),
        .right_valid_o  (right_valid),
        .frame_valid_o  (frame_valid)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int nl = 0, nr = 0, nf = 0;
    logic [23:0] got_l = '0, got_r = '0;

    // Each row: word-length code, left word, right word.
    localparam int NVEC = 8;
    localparam logic [65:0] VEC [NVEC] = '{
        {2'b10, 32'h00123456, 32'h00FEDCBA},
        {2'b00, 32'h89ABCDEF, 32'h7FFFFFFF},
        {2'b11, 32'h000ABCDE, 32'h00080000},
        {2'b01, 32'h00001234, 32'h0000FFFF},
        {2'b10, 32'h00800000, 32'h007FFFFF},
        {2'b00, 32'h000000FF, 32'hFFFFFF80},
        {2'b11, 32'h0007FFFF, 32'h000FFFFF},
        {2'b01, 32'h00008000, 32'h00000001}
    };

    // Monitor: sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (left_valid)  begin got_l = left_sample;  nl++; end
            if (right_valid) begin got_r = right_sample; nr++; end
            if (frame_valid) nf++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] len_mask(input logic [1:0] code);
        case (code)
            2'b00:   return 32'hFFFFFFFF;
            2'b10:   return 32'h00FFFFFF;
            2'b11:   return 32'h000FFFFF;
            default: return 32'h0000FFFF;
        endcase
    endfunction

    function automatic logic [23:0] expect_of(input logic [31:0] w, input logic [1:0] code);
        case (code)
            2'b10:   return w[23:0];
            2'b00:   return w[31:8];
            2'b11:   return {w[19:0], 4'h0};
            default: return {w[15:0], 8'h00};
        endcase
    endfunction

    function automatic string req_of(input logic [1:0] code);
        case (code)
            2'b10:   return "R4";
            2'b00:   return "R5";
            2'b11:   return "R6";
            default: return "R7";
        endcase
    endfunction

    // Filler ahead of shorter words must be ignored (R2).
    function automatic logic [31:0] on_wire(input logic [31:0] w, input logic [1:0] code);
        return (w & len_mask(code)) | (32'hC3A55A3C & ~len_mask(code));
    endfunction

    task automatic send_half(input logic [31:0] v);
        for (int i = 31; i >= 0; i--) begin
            sdata = v[i];
            bclk  = 1'b1;
            repeat (4) @(posedge clk);
            bclk  = 1'b0;
            repeat (4) @(posedge clk);
        end
        bclk = 1'b1;
        repeat (2) @(posedge clk);
    endtask

    task automatic set_wc(input logic lv);
        wclk = lv;
        repeat (2) @(posedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R1 left sample in reset",  {8'h0, left_sample},  32'h0);
        check("R1 right sample in reset", {8'h0, right_sample}, 32'h0);
        check("R1 strobes in reset", {29'h0, left_valid, right_valid, frame_valid}, 32'h0);
        @(posedge clk);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 strobes after reset", {29'h0, left_valid, right_valid, frame_valid}, 32'h0);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int bl, br, bf;
        logic [23:0] el, er;

        // Reset with polarity 1: word clock low = right, so no edge at release.
        pol = 1'b1; wclk = 1'b0;
        do_reset();

        // R10: junk half while aligning, then the first transition stores nothing.
        send_half(32'hFFFF0000);
        set_wc(1'b1);
        repeat (10) @(posedge clk);
        @(negedge clk);
        check("R10 no left strobe on first edge",  nl, 0);
        check("R10 no right strobe on first edge", nr, 0);

        // Table walk (R2..R9), polarity 1.
        for (int v = 0; v < NVEC; v++) begin
            logic [1:0]  code;
            logic [31:0] lw, rw;
            code = VEC[v][65:64];
            lw   = VEC[v][63:32];
            rw   = VEC[v][31:0];
            wlen = code;
            bl = nl; br = nr; bf = nf;
            el = expect_of(lw, code);
            er = expect_of(rw, code);
            set_wc(1'b1);
            send_half(on_wire(lw, code));
            set_wc(1'b0);
            send_half(on_wire(rw, code));
            set_wc(1'b1);
            repeat (12) @(posedge clk);
            @(negedge clk);
            check({req_of(code), " R2 left word"},  {8'h0, got_l}, {8'h0, el});
            check({req_of(code), " R2 right word"}, {8'h0, got_r}, {8'h0, er});
            check("R8 one left strobe",  nl - bl, 1);
            check("R8 one right strobe", nr - br, 1);
            check("R9 one frame strobe", nf - bf, 1);
            check("R8 left output held", {8'h0, left_sample}, {8'h0, el});
        end

        // R1: reset after activity clears everything.
        wclk = 1'b0;
        pol  = 1'b0;
        do_reset();

        // R3 reversed polarity: word clock high = right, low = left.
        wlen = 2'b10;
        nl = 0; nr = 0; nf = 0;
        send_half(32'h00AAAAAA);
        set_wc(1'b1);
        repeat (10) @(posedge clk);
        @(negedge clk);
        check("R10 no strobe on first edge (polarity 0)", nl + nr, 0);
        send_half(32'h00654321);
        set_wc(1'b0);
        repeat (10) @(posedge clk);
        @(negedge clk);
        check("R3 right word stored while high (polarity 0)", {8'h0, got_r}, 32'h00654321);
        check("R3 right edge leaves left untouched", nl, 0);
        check("R9 frame after right (polarity 0)", nf, 1);
        send_half(32'h00C0FFEE);
        set_wc(1'b1);
        repeat (10) @(posedge clk);
        @(negedge clk);
        check("R3 left word stored while low (polarity 0)", {8'h0, got_l}, 32'h00C0FFEE);
        check("R3 right output unchanged by left store", {8'h0, right_sample}, 32'h00654321);
        check("R9 no frame strobe after left", nf, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule